// File: doc/BRIEF.md
# LCD common row scanner

This block is the logic core of a common (row) driver for a passive-matrix STN LCD. A chain of row-select bits, one per row, advances by one position on each line strobe. A single 1 travelling through the chain marks the row being scanned. Each row output is a 2-bit code that picks one of four drive levels. The code depends on whether the row is selected and on the frame-inversion phase. A display-blank input forces every row to one fixed level at once, without touching the chain.

The chain can shift toward the high end or toward the low end. It can also be cut at its midpoint into two half-length chains, so that two screens are scanned in parallel. The second half then takes its serial input from a dedicated input. The serial pins at both ends let several devices be cascaded for longer duties. Each end pin has an output value and an output enable, so the input end and the output end swap when the direction is reversed.

The shift chain runs in one of four configurations, named as states:
- `CFG_FULL_FWD` (whole chain, shifting upward)
- `CFG_FULL_REV` (whole chain, shifting downward)
- `CFG_SPLIT_FWD` (two halves, shifting upward)
- `CFG_SPLIT_REV` (two halves, shifting downward)

The configuration is taken from `dir` and `split` in every cycle. Changing `dir` moves between the FWD and REV states. Changing `split` moves between the FULL and SPLIT states. The state in force when `load` is high decides how the next shift is done.

Top module: `lcd_row_scanner`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every chain bit to 0. With frame 0 and display enabled, every row then reads the non-select code 2'b10.
- R2: In a cycle where `load` is low, the chain holds its contents, whatever the serial inputs do.
- R3: In CFG_FULL_FWD (`dir`=0, `split`=0), each `load` moves bit i to bit i+1 and loads `end_lo_in` into bit 0. A token entered at bit 0 reaches `end_hi_out` after ROWS loads.
- R4: In CFG_FULL_REV (`dir`=1, `split`=0), each `load` moves bit i to bit i-1 and loads `end_hi_in` into bit ROWS-1.
- R5: In CFG_SPLIT_FWD (`dir`=0, `split`=1), the lower half (bits 0..ROWS/2-1) shifts upward from `end_lo_in`. The upper half shifts upward from `scr2_in` entering at bit ROWS/2. Bit ROWS/2-1 is not passed across the seam.
- R6: In CFG_SPLIT_REV (`dir`=1, `split`=1), the upper half shifts downward from `end_hi_in`. The lower half shifts downward from `scr2_in` entering at bit ROWS/2-1.
- R7: With `dir`=0, `end_hi_oe`=1 and `end_lo_oe`=0. With `dir`=1 the enables are swapped. `end_lo_out` always shows bit 0 and `end_hi_out` always shows bit ROWS-1.
- R8: Row r occupies `row_lvl[2r+1:2r]` and uses the codes V0=2'b00, V1=2'b01, V4=2'b10, V5=2'b11. A selected row gives V0 in frame 0 and V5 in frame 1. An unselected row gives V4 in frame 0 and V1 in frame 1.
- R9: While `disp_on` is low, every row reads 2'b11 in the same cycle, with no clock edge needed. Loads still shift the chain, and the levels reflect the chain again as soon as `disp_on` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Line strobe; shifts the chain once per cycle it is high |
| dir | input | 1 | 0 shifts toward the high end, 1 toward the low end |
| split | input | 1 | 1 cuts the chain into two halves |
| frame | input | 1 | Frame-inversion phase |
| disp_on | input | 1 | 0 blanks every row to 2'b11 |
| end_lo_in | input | 1 | Serial input at the low end (used when dir=0) |
| end_hi_in | input | 1 | Serial input at the high end (used when dir=1) |
| scr2_in | input | 1 | Serial input of the second half in split mode |
| end_lo_out | output | 1 | Bit 0 of the chain |
| end_lo_oe | output | 1 | Output enable of the low-end pin |
| end_hi_out | output | 1 | Bit ROWS-1 of the chain |
| end_hi_oe | output | 1 | Output enable of the high-end pin |
| row_lvl | output | 2*ROWS | Drive-level code of every row |

## Verification
A shift by `load` and a display-blank can fall in the same cycle. To provoke this, the bench drops `disp_on` for several strobes in the middle of a token walk. It judges that every row reads 2'b11 during those strobes, and that the token then shows at the position the uncounted-for loads carried it to once the display returns. A frame flip and a shift also coincide on every seventh strobe, and the bench expects the new position with the new frame's codes in that same cycle. In split mode both halves take a new serial bit on the same strobe, and the bench judges the seam bits from a model that never lets a bit cross it.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V1 = 2'b01,
        LVL_V4 = 2'b10,
        LVL_V5 = 2'b11
    } drive_lvl_e;

    typedef enum logic [1:0] {
        CFG_FULL_FWD  = 2'b00,
        CFG_FULL_REV  = 2'b01,
        CFG_SPLIT_FWD = 2'b10,
        CFG_SPLIT_REV = 2'b11
    } chain_cfg_e;

endpackage

// File: rtl/scan_cfg_decode.sv
module scan_cfg_decode
    import lcd_scan_pkg::*;
(
    input  logic       dir,
    input  logic       split,
    output chain_cfg_e cfg,
    output logic       lo_oe,
    output logic       hi_oe
);

    always_comb begin
        unique case ({split, dir})
            2'b00:   cfg = CFG_FULL_FWD;
            2'b01:   cfg = CFG_FULL_REV;
            2'b10:   cfg = CFG_SPLIT_FWD;
            default: cfg = CFG_SPLIT_REV;
        endcase
    end

    always_comb begin
        unique case (cfg)
            CFG_FULL_FWD, CFG_SPLIT_FWD: begin
                lo_oe = 1'b0;
                hi_oe = 1'b1;
            end
            default: begin
                lo_oe = 1'b1;
                hi_oe = 1'b0;
            end
        endcase
    end

    always_comb begin
        AST_PIN_ROLES: assert (lo_oe == dir && hi_oe == !dir); // R7
    end

endmodule

// File: rtl/row_shift_chain.sv
module row_shift_chain
    import lcd_scan_pkg::*;
#(
    parameter int ROWS = 160
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  chain_cfg_e      cfg,
    input  logic            lo_in,
    input  logic            hi_in,
    input  logic            b_in,
    output logic [ROWS-1:0] chain
);

    localparam int HALF = ROWS / 2;

    logic [ROWS-1:0] nxt;

    always_comb begin
        unique case (cfg)
            CFG_FULL_FWD:  nxt = {chain[ROWS-2:0], lo_in};
            CFG_FULL_REV:  nxt = {hi_in, chain[ROWS-1:1]};
            CFG_SPLIT_FWD: nxt = {chain[ROWS-2:HALF], b_in, chain[HALF-2:0], lo_in};
            default:       nxt = {hi_in, chain[ROWS-1:HALF+1], b_in, chain[HALF-1:1]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (load) begin
            chain <= nxt;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(chain)); // R2

    AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (load && cfg == CFG_FULL_FWD) |=> (chain[0] == $past(lo_in)
                                           && chain[ROWS-1] == $past(chain[ROWS-2]))); // R3

    AST_REV_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (load && cfg == CFG_FULL_REV) |=> (chain[ROWS-1] == $past(hi_in)
                                           && chain[0] == $past(chain[1]))); // R4

    AST_SPLIT_FWD_SEAM: assert property (@(posedge clk) disable iff (rst)
        (load && cfg == CFG_SPLIT_FWD) |=> (chain[HALF] == $past(b_in)
                                            && chain[0] == $past(lo_in))); // R5

    AST_SPLIT_REV_SEAM: assert property (@(posedge clk) disable iff (rst)
        (load && cfg == CFG_SPLIT_REV) |=> (chain[HALF-1] == $past(b_in)
                                            && chain[ROWS-1] == $past(hi_in))); // R6

endmodule

// File: rtl/row_level_map.sv
module row_level_map
    import lcd_scan_pkg::*;
#(
    parameter int ROWS = 160
) (
    input  logic [ROWS-1:0]   chain,
    input  logic              frame,
    input  logic              disp_on,
    output logic [2*ROWS-1:0] row_lvl
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        drive_lvl_e lvl;
        always_comb begin
            unique case ({disp_on, chain[r], frame})
                3'b100:  lvl = LVL_V4;
                3'b101:  lvl = LVL_V1;
                3'b110:  lvl = LVL_V0;
                3'b111:  lvl = LVL_V5;
                default: lvl = LVL_V5;
            endcase
        end
        assign row_lvl[2*r +: 2] = lvl;
    end

    always_comb begin
        if (!disp_on) begin
            AST_BLANK_LEVEL: assert (row_lvl == '1); // R9
        end
    end

endmodule

// File: rtl/lcd_row_scanner.sv
module lcd_row_scanner
    import lcd_scan_pkg::*;
#(
    parameter int ROWS = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              dir,
    input  logic              split,
    input  logic              frame,
    input  logic              disp_on,
    input  logic              end_lo_in,
    input  logic              end_hi_in,
    input  logic              scr2_in,
    output logic              end_lo_out,
    output logic              end_lo_oe,
    output logic              end_hi_out,
    output logic              end_hi_oe,
    output logic [2*ROWS-1:0] row_lvl
);

    chain_cfg_e      cfg;
    logic [ROWS-1:0] chain;

    scan_cfg_decode u_cfg (
        .dir   (dir),
        .split (split),
        .cfg   (cfg),
        .lo_oe (end_lo_oe),
        .hi_oe (end_hi_oe)
    );

    row_shift_chain #(.ROWS(ROWS)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .cfg   (cfg),
        .lo_in (end_lo_in),
        .hi_in (end_hi_in),
        .b_in  (scr2_in),
        .chain (chain)
    );

    row_level_map #(.ROWS(ROWS)) u_map (
        .chain   (chain),
        .frame   (frame),
        .disp_on (disp_on),
        .row_lvl (row_lvl)
    );

    assign end_lo_out = chain[0];
    assign end_hi_out = chain[ROWS-1];

    AST_RESET_ROWS: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(load) && disp_on) |-> (end_lo_out == 1'b0 && end_hi_out == 1'b0)); // R1

endmodule

// File: tb/lcd_row_scanner_bench.sv
module lcd_row_scanner_bench;

    localparam int ROWS = 160;
    localparam int HALF = ROWS / 2;

    typedef struct {
        logic [2*ROWS-1:0] lvl;
        logic              lo_oe;
        logic              hi_oe;
        logic              lo_out;
        logic              hi_out;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load = 1'b0;
    logic              dir = 1'b0;
    logic              split = 1'b0;
    logic              frame = 1'b0;
    logic              disp_on = 1'b1;
    logic              end_lo_in = 1'b0;
    logic              end_hi_in = 1'b0;
    logic              scr2_in = 1'b0;
    logic              end_lo_out, end_lo_oe, end_hi_out, end_hi_oe;
    logic [2*ROWS-1:0] row_lvl;

    int   checks = 0;
    int   fails  = 0;
    bit   model [ROWS];
    exp_t sb_q[$];

    always #10 clk = ~clk;

    lcd_row_scanner #(.ROWS(ROWS)) u_lcd_row_scanner (
        .clk(clk), .rst(rst), .load(load), .dir(dir), .split(split),
        .frame(frame), .disp_on(disp_on), .end_lo_in(end_lo_in),
        .end_hi_in(end_hi_in), .scr2_in(scr2_in), .end_lo_out(end_lo_out),
        .end_lo_oe(end_lo_oe), .end_hi_out(end_hi_out), .end_hi_oe(end_hi_oe),
        .row_lvl(row_lvl)
    );

    // R8 code table: sel/frame -> V0/V5, unsel/frame -> V4/V1; R9 blank -> 11
    function automatic logic [1:0] lvl_of(bit sel, logic f, logic d);
        if (!d) return 2'b11;
        if (sel) return f ? 2'b11 : 2'b00;
        return f ? 2'b01 : 2'b10;
    endfunction

    task automatic step(input logic r, input logic ld, input logic dr, input logic sp,
                        input logic fr, input logic dp, input logic li, input logic hi,
                        input logic bi);
        bit   nm [ROWS];
        exp_t e;
        @(negedge clk);
        rst = r; load = ld; dir = dr; split = sp; frame = fr; disp_on = dp;
        end_lo_in = li; end_hi_in = hi; scr2_in = bi;
        if (r) begin
            for (int i = 0; i < ROWS; i++) model[i] = 1'b0;
            e.tag = "R1";
        end else if (ld) begin
            for (int i = 0; i < ROWS; i++) begin
                if (!dr && !sp)     nm[i] = (i == 0) ? li : model[i-1];          // R3
                else if (dr && !sp) nm[i] = (i == ROWS-1) ? hi : model[i+1];     // R4
                else if (!dr)       nm[i] = (i == 0) ? li : (i == HALF) ? bi : model[i-1]; // R5
                else                nm[i] = (i == ROWS-1) ? hi : (i == HALF-1) ? bi : model[i+1]; // R6
            end
            model = nm;
            e.tag = !dp ? "R9" : (!sp ? (!dr ? "R3" : "R4") : (!dr ? "R5" : "R6"));
        end else begin
            e.tag = !dp ? "R9" : "R2";
        end
        for (int i = 0; i < ROWS; i++) e.lvl[2*i +: 2] = lvl_of(model[i], fr, dp);
        e.lo_oe  = dr;
        e.hi_oe  = !dr;
        e.lo_out = model[0];
        e.hi_out = model[ROWS-1];
        sb_q.push_back(e);
    endtask

    // monitor: sample 2 ns after the edge that follows each drive
    initial begin
        exp_t e;
        forever begin
            wait (sb_q.size() > 0);
            @(posedge clk);
            #2;
            e = sb_q.pop_front();
            checks++;
            if (row_lvl !== e.lvl) begin
                fails++;
                $display("FAIL %s/R8 row_lvl got %h exp %h", e.tag, row_lvl, e.lvl);
            end
            checks++;
            if ({end_lo_oe, end_hi_oe, end_lo_out, end_hi_out} !==
                {e.lo_oe, e.hi_oe, e.lo_out, e.hi_out}) begin
                fails++;
                $display("FAIL %s/R7 pins got %b exp %b", e.tag,
                         {end_lo_oe, end_hi_oe, end_lo_out, end_hi_out},
                         {e.lo_oe, e.hi_oe, e.lo_out, e.hi_out});
            end
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired got running exp finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset clears, frame 0 non-select
        step(1, 0, 0, 0, 0, 1, 1, 1, 1);
        step(1, 1, 0, 0, 0, 1, 1, 1, 1);
        // R8: frame 1 non-select code
        step(0, 0, 0, 0, 1, 1, 0, 0, 0);
        // R3 walk with frame flips (R8) and a blank window during shifts (R9)
        for (int k = 0; k < 165; k++)
            step(0, 1, 0, 0, logic'((k / 7) % 2), !(k >= 50 && k < 54),
                 logic'(k == 0 || k == 20), 1, 1);
        // R2: no load, inputs toggling
        for (int k = 0; k < 6; k++)
            step(0, 0, logic'(k % 2), logic'(k / 3), 0, 1, 1, 1, 1);
        // R4 walk from the high end
        step(1, 0, 1, 0, 0, 1, 0, 0, 0);
        for (int k = 0; k < 165; k++)
            step(0, 1, 1, 0, logic'((k / 5) % 2), !(k == 90), 1, logic'(k == 0 || k == 33), 1);
        // R5 split upward
        step(1, 0, 0, 1, 0, 1, 0, 0, 0);
        for (int k = 0; k < 90; k++)
            step(0, 1, 0, 1, logic'(k % 2), 1, logic'(k % 5 == 0), 1, logic'(k % 3 == 0));
        // R6 split downward
        step(1, 0, 1, 1, 0, 1, 0, 0, 0);
        for (int k = 0; k < 90; k++)
            step(0, 1, 1, 1, 0, 1, 1, logic'(k % 4 == 0), logic'(k % 7 == 1));
        // mixed configurations on a populated chain
        for (int k = 0; k < 40; k++)
            step(0, logic'(k % 3 != 2), logic'((k / 4) % 2), logic'((k / 8) % 2),
                 logic'(k % 2), !(k == 17), logic'(k % 6 == 0), logic'(k % 5 == 1),
                 logic'(k % 4 == 3));
        wait (sb_q.size() == 0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule